// File: doc/BRIEF.md
# Interrupt Destination Match Logic

This block decides whether one local interrupt unit is a target of an inter-processor message. It takes the destination of the message as carried on the request: a two-bit shorthand, a physical/logical mode bit and an 8-bit destination field, plus a flag that says whether this unit sent the message. It compares these against the unit's own addressing state: its identifier register, its logical-destination register and its destination-format register. The result is one combinational match bit.

Shorthands select the unit itself, every unit, or every unit except the sender, without looking at the destination field. With no shorthand, physical mode compares the field with the unit's identifier and also accepts a broadcast value. Logical mode uses either flat addressing, where each bit of the field picks one unit, or cluster addressing, where the upper nibble names a cluster and the lower nibble picks members within it. The format register selects between the two. A format value that names neither gives no match. When such a value is met on a qualified request, a registered fault flag is raised for one cycle. Queuing of messages, handling of delivery modes and arbitration among several matching units are left to the surrounding logic.

The match path has no handshake because it is a pure decision with no storage. `req_valid` is a plain strobe. It only qualifies the fault flag and never stalls anything.

Top module: `ipi_dest_match`

## Requirements
- R1: With shorthand code 0 (none), the match depends only on the mode bit (0 = physical, 1 = logical), the destination field and the unit's registers, never on `is_sender`.
- R2: Shorthand code 1 (self) matches when `is_sender` is 1 and does not match when it is 0.
- R3: Shorthand code 2 (all including self) always matches.
- R4: Shorthand code 3 (all excluding self) matches when `is_sender` is 0 and does not match when it is 1.
- R5: With no shorthand in physical mode, a destination field of 0xFF matches every unit.
- R6: With no shorthand in physical mode, any other destination matches only when it equals `id_reg[31:24]`.
- R7: In logical flat format, the unit matches when `ldr_reg[31:24] & dest_field` is non-zero.
- R8: In logical cluster format, bits [7:4] of `ldr_reg[31:24]` and of `dest_field` must be equal, and the AND of their bits [3:0] must be non-zero.
- R9: `fmt_reg` equal to 0xFFFFFFFF selects flat format and 0x0FFFFFFF selects cluster format. Any other value gives no match in logical mode.
- R10: `fmt_fault` is 0 after reset. It is 1 in exactly the cycle after a clock edge at which `req_valid` was 1 with no shorthand, logical mode and an unrecognised format value, and 0 otherwise.
- R11: With a shorthand or in physical mode, `fmt_reg` has no effect on `hit` and never raises `fmt_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fault flag |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Qualifies the current request for fault reporting |
| sh_code | input | 2 | Shorthand: 0 none, 1 self, 2 all, 3 all but self |
| logical_mode | input | 1 | 0 physical, 1 logical destination |
| dest_field | input | 8 | Destination of the message |
| is_sender | input | 1 | This unit originated the message |
| id_reg | input | 32 | Identifier register, physical ID in bits 31:24 |
| ldr_reg | input | 32 | Logical-destination register, logical ID in bits 31:24 |
| fmt_reg | input | 32 | Destination-format register |
| hit | output | 1 | This unit is a target (combinational) |
| fmt_fault | output | 1 | One-cycle flag for an unrecognised format on a request |

## Verification
The assertions watch the shorthand rules on every cycle: all-including always hits, self without sender and all-excluding with sender never hit, and the physical broadcast always hits. They also check that the fault flag only follows a qualified request, and never one with a shorthand or in physical mode. The arithmetic of the addressing modes can only be shown by the bench's scenarios, which compare against a behavioural reference every clock. These are the equality against the physical ID, the flat overlap test, the cluster nibble split, and the exact format values that separate flat, cluster and invalid. The one-cycle timing of the fault flag is shown the same way.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;
  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef enum logic [1:0] {
    FMT_FLAT    = 2'd0,
    FMT_CLUSTER = 2'd1,
    FMT_INVALID = 2'd2
  } addr_fmt_e;
endpackage

// File: rtl/ipi_fmt_decode.sv
module ipi_fmt_decode
  import ipi_dest_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int HEAD_W = 4
) (
  input  logic [REG_W-1:0] fmt_reg,
  output addr_fmt_e        fmt
);
  localparam int TAIL_W = REG_W - HEAD_W;
  localparam logic [REG_W-1:0] FLAT_CODE    = {REG_W{1'b1}};
  localparam logic [REG_W-1:0] CLUSTER_CODE = {{HEAD_W{1'b0}}, {TAIL_W{1'b1}}};

  always_comb begin
    if (fmt_reg == FLAT_CODE)         fmt = FMT_FLAT;
    else if (fmt_reg == CLUSTER_CODE) fmt = FMT_CLUSTER;
    else                              fmt = FMT_INVALID;
  end
endmodule

// File: rtl/ipi_phys_cmp.sv
module ipi_phys_cmp #(
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0] unit_id,
  input  logic [ID_W-1:0] dest,
  output logic            match
);
  localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

  logic is_bcast;
  logic is_equal;

  assign is_bcast = (dest == BCAST);
  assign is_equal = (dest == unit_id);
  assign match    = is_bcast | is_equal;
endmodule

// File: rtl/ipi_logic_cmp.sv
module ipi_logic_cmp
  import ipi_dest_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int GRP_W = 4
) (
  input  logic [ID_W-1:0] logical_id,
  input  logic [ID_W-1:0] dest,
  input  addr_fmt_e       fmt,
  output logic            match
);
  localparam int MEM_W = ID_W - GRP_W;

  logic flat_hit;
  logic cluster_hit;
  logic grp_equal;
  logic [MEM_W-1:0] member_and;

  assign flat_hit = |(logical_id & dest);

  generate
    if (GRP_W > 0) begin : g_grouped
      assign grp_equal = (logical_id[ID_W-1:MEM_W] == dest[ID_W-1:MEM_W]);
    end else begin : g_ungrouped
      assign grp_equal = 1'b1;
    end
  endgenerate

  assign member_and  = logical_id[MEM_W-1:0] & dest[MEM_W-1:0];
  assign cluster_hit = grp_equal & (|member_and);

  always_comb begin
    unique case (fmt)
      FMT_FLAT:    match = flat_hit;
      FMT_CLUSTER: match = cluster_hit;
      default:     match = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
  import ipi_dest_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int REG_W  = 32,
  parameter int GRP_W  = 4,
  parameter int HEAD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       sh_code,
  input  logic             logical_mode,
  input  logic [ID_W-1:0]  dest_field,
  input  logic             is_sender,
  input  logic [REG_W-1:0] id_reg,
  input  logic [REG_W-1:0] ldr_reg,
  input  logic [REG_W-1:0] fmt_reg,
  output logic             hit,
  output logic             fmt_fault
);
  localparam int ID_LSB = REG_W - ID_W;

  shorthand_e sh;
  addr_fmt_e  fmt;
  logic       phys_hit;
  logic       logic_hit;
  logic       addressed_hit;
  logic       fault_now;

  assign sh = shorthand_e'(sh_code);

  ipi_fmt_decode #(.REG_W(REG_W), .HEAD_W(HEAD_W)) u_fmt (
    .fmt_reg (fmt_reg),
    .fmt     (fmt)
  );

  ipi_phys_cmp #(.ID_W(ID_W)) u_phys (
    .unit_id (id_reg[REG_W-1:ID_LSB]),
    .dest    (dest_field),
    .match   (phys_hit)
  );

  ipi_logic_cmp #(.ID_W(ID_W), .GRP_W(GRP_W)) u_logic (
    .logical_id (ldr_reg[REG_W-1:ID_LSB]),
    .dest       (dest_field),
    .fmt        (fmt),
    .match      (logic_hit)
  );

  assign addressed_hit = logical_mode ? logic_hit : phys_hit;

  always_comb begin
    unique case (sh)
      SH_NONE:   hit = addressed_hit;
      SH_SELF:   hit = is_sender;
      SH_ALL:    hit = 1'b1;
      SH_OTHERS: hit = ~is_sender;
      default:   hit = 1'b0;
    endcase
  end

  assign fault_now = req_valid && (sh == SH_NONE) && logical_mode &&
                     (fmt == FMT_INVALID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fmt_fault <= 1'b0;
    else        fmt_fault <= fault_now;
  end

  a_r3_all_always_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_code == 2'd2) |-> hit);

  a_r2_self_needs_sender: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_code == 2'd1 && !is_sender) |-> !hit);

  a_r4_others_skip_sender: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_code == 2'd3 && is_sender) |-> !hit);

  a_r5_bcast_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_code == 2'd0 && !logical_mode && dest_field == {ID_W{1'b1}}) |-> hit);

  a_r9_invalid_fmt_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_code == 2'd0 && logical_mode && fmt_reg != {REG_W{1'b1}} &&
     fmt_reg != {{HEAD_W{1'b0}}, {(REG_W-HEAD_W){1'b1}}}) |-> !hit);

  a_r10_fault_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_fault |-> $past(req_valid));

  a_r11_no_fault_outside_logical: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(sh_code == 2'd0 && logical_mode)) |=> !fmt_fault);
endmodule

// File: tb/tb_ipi_dest_match.sv
module tb_ipi_dest_match;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  sh_code = 2'd0;
  logic        logical_mode = 1'b0;
  logic [7:0]  dest_field = 8'd0;
  logic        is_sender = 1'b0;
  logic [31:0] id_reg = 32'd0;
  logic [31:0] ldr_reg = 32'd0;
  logic [31:0] fmt_reg = 32'hFFFF_FFFF;
  logic        hit;
  logic        fmt_fault;

  int checks = 0;
  int failures = 0;
  bit prev_bad = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ipi_dest_match dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .sh_code(sh_code),
    .logical_mode(logical_mode), .dest_field(dest_field), .is_sender(is_sender),
    .id_reg(id_reg), .ldr_reg(ldr_reg), .fmt_reg(fmt_reg),
    .hit(hit), .fmt_fault(fmt_fault)
  );

  function automatic bit ref_hit();
    int lid, d;
    lid = int'(ldr_reg[31:24]);
    d   = int'(dest_field);
    case (sh_code)
      2'd1: return is_sender;
      2'd2: return 1'b1;
      2'd3: return !is_sender;
      default: begin
        if (!logical_mode) return (d == 255) || (d == int'(id_reg[31:24]));
        if (fmt_reg == 32'hFFFF_FFFF) return (lid & d) != 0;
        if (fmt_reg == 32'h0FFF_FFFF)
          return ((lid / 16) == (d / 16)) && (((lid % 16) & (d % 16)) != 0);
        return 1'b0;
      end
    endcase
  endfunction

  function automatic string ref_tag();
    case (sh_code)
      2'd1: return "R2";
      2'd2: return "R3";
      2'd3: return "R4";
      default: begin
        if (!logical_mode) return (dest_field == 8'hFF) ? "R1/R5" : "R1/R6";
        if (fmt_reg == 32'hFFFF_FFFF) return "R1/R7";
        if (fmt_reg == 32'h0FFF_FFFF) return "R1/R8";
        return "R9";
      end
    endcase
  endfunction

  function automatic bit ref_bad();
    return req_valid && sh_code == 2'd0 && logical_mode &&
           fmt_reg != 32'hFFFF_FFFF && fmt_reg != 32'h0FFF_FFFF;
  endfunction

  task automatic check(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] s, input bit lm, input logic [7:0] d,
                      input bit snd, input logic [7:0] pid, input logic [7:0] lid,
                      input logic [31:0] f);
    @(posedge clk);
    #2;
    req_valid = v; sh_code = s; logical_mode = lm; dest_field = d; is_sender = snd;
    id_reg = {pid, 24'h00_1234}; ldr_reg = {lid, 24'h00_0ABC}; fmt_reg = f;
    @(negedge clk);
    check(hit, ref_hit(), ref_tag());
    check(fmt_fault, prev_bad, prev_bad ? "R10" : "R10/R11");
    prev_bad = ref_bad();
  endtask

  initial begin
    #100000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fmt_fault, 1'b0, "R10 reset");
    rst_n = 1'b1;
    // physical
    step(1, 0, 0, 8'h05, 0, 8'h05, 8'h00, 32'h1234_5678); // R6 equal, fmt ignored R11
    step(1, 0, 0, 8'h06, 0, 8'h05, 8'h00, 32'hFFFF_FFFF); // R6 mismatch
    step(1, 0, 0, 8'hFF, 1, 8'h33, 8'h00, 32'h0000_0000); // R5 broadcast
    step(1, 0, 0, 8'h33, 1, 8'h33, 8'h00, 32'hFFFF_FFFF); // R1 sender no effect
    // flat
    step(1, 0, 1, 8'h81, 0, 8'h00, 8'h01, 32'hFFFF_FFFF); // R7 overlap
    step(1, 0, 1, 8'h80, 0, 8'h00, 8'h01, 32'hFFFF_FFFF); // R7 no overlap
    // cluster
    step(1, 0, 1, 8'h23, 0, 8'h00, 8'h21, 32'h0FFF_FFFF); // R8 hit
    step(1, 0, 1, 8'h33, 0, 8'h00, 8'h21, 32'h0FFF_FFFF); // R8 other cluster
    step(1, 0, 1, 8'h24, 0, 8'h00, 8'h21, 32'h0FFF_FFFF); // R8 no member
    step(1, 0, 1, 8'h21, 0, 8'h00, 8'h21, 32'hFFFF_FFFE); // R9 invalid -> fault next
    step(0, 0, 1, 8'h21, 0, 8'h00, 8'h21, 32'h1FFF_FFFF); // R10 not qualified
    step(1, 0, 1, 8'hFF, 0, 8'h00, 8'hFF, 32'h0000_0000); // R9 invalid again
    step(1, 0, 1, 8'hFF, 0, 8'h00, 8'hFF, 32'h0000_0000); // back-to-back
    // shorthands with an invalid format present: R11
    step(1, 1, 1, 8'h00, 1, 8'h00, 8'h00, 32'h0000_0000);
    step(1, 1, 0, 8'hFF, 0, 8'hFF, 8'h00, 32'h0000_0000);
    step(1, 2, 1, 8'h00, 0, 8'h00, 8'h00, 32'h0000_0000);
    step(1, 3, 1, 8'h00, 1, 8'h00, 8'h00, 32'h0000_0000);
    step(1, 3, 0, 8'h00, 0, 8'h00, 8'h00, 32'h0000_0000);
    step(0, 0, 0, 8'h00, 0, 8'h00, 8'h00, 32'hFFFF_FFFF);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] f;
      logic [7:0] pid, lid, d;
      int pick;
      pick = $urandom_range(0, 2);
      f = (pick == 0) ? 32'hFFFF_FFFF : (pick == 1) ? 32'h0FFF_FFFF : $urandom;
      pid = 8'($urandom); lid = 8'($urandom); d = 8'($urandom);
      if ($urandom_range(0, 3) == 0) d = pid;
      if ($urandom_range(0, 7) == 0) d = 8'hFF;
      step(1'($urandom), 2'($urandom), 1'($urandom), d, 1'($urandom), pid, lid, f);
    end
    step(0, 0, 0, 8'h00, 0, 8'h00, 8'h00, 32'hFFFF_FFFF);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule